// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block answers the processor's interrupt-acknowledge handshake. It watches an active-low acknowledge strobe, counts the pulses of one acknowledge sequence, and puts the right byte on the data bus during each pulse. Two protocols are supported. In the narrow-processor protocol a sequence has three pulses: a call opcode, then the low and high bytes of the service address. In the wide-processor protocol a sequence has two pulses: the first drives nothing and the second carries an 8-bit vector number. The service address and the vector are built from programmed fields and the level that won priority resolution. That level is captured at the first pulse.

When several controllers are chained, a master whose winning input feeds a slave puts that input number on a 3-bit chain bus. The slave whose programmed ID matches the chain bus then supplies the vector bytes. The master still supplies the opcode. In automatic clear mode the block emits a one-cycle clear pulse carrying the serviced level at the end of the final pulse. An interrupted sequence returns to idle after a programmable number of idle strobe cycles, or when the protocol selection changes. The strobe is sampled on the clock, and all outputs are registered or derived from registered state.

Top module: `ack_vector_seq`

## Requirements
- R1: While rst_n is low, vec_oe, vec_byte, casc_oe, casc_out and isr_clr are all zero.
- R2: With wide_mode=0, the first pulse of a sequence drives vec_byte=8'hCD on a single or master device. vec_oe rises one clock after iack_n is sampled low and falls one clock after iack_n is sampled high.
- R3: With wide_mode=0 and step4=1, the second pulse drives {call_lo[2:0], level[2:0], 2'b00}.
- R4: With wide_mode=0 and step4=0, the second pulse drives {call_lo[2:1], level[2:0], 3'b000}.
- R5: With wide_mode=0, the third pulse drives call_hi and ends the sequence.
- R6: With wide_mode=1, the first pulse leaves vec_oe low. The second drives {vec_top[4:0], level[2:0]} and ends the sequence.
- R7: The level is taken from req_level at the first pulse and held for the whole sequence. If req_valid is low at the first pulse, level 7 is used.
- R8: With chain_en=1 and chain_master=1, if chain_map bit [level] is set, casc_oe is high and casc_out equals the level from the clock after the first pulse until the sequence ends. In that case the device drives only the opcode pulse. casc_oe is never high on a non-master.
- R9: With chain_en=1 and chain_master=0, the device never drives the opcode. It drives vector pulses only when casc_in equals chain_id at the start of the pulse.
- R10: With auto_clr=1, isr_clr pulses for exactly one clock after the final pulse's rising strobe, and isr_clr_lvl equals the level. There is no pulse when auto_clr=0, or on a chained slave that did not supply the vector.
- R11: If iack_n is sampled high for GAP_LIMIT consecutive clocks in mid-sequence, the next pulse is treated as the first of a new sequence.
- R12: If wide_mode differs from its value at the first pulse while iack_n is high in mid-sequence, the sequence is abandoned.
- R13: vec_byte is zero whenever vec_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iack_n | input | 1 | Acknowledge strobe, active low |
| req_valid | input | 1 | A resolved request exists |
| req_level | input | 3 | Winning level from the priority resolver |
| wide_mode | input | 1 | 1: two-pulse vector protocol, 0: three-pulse call protocol |
| step4 | input | 1 | Call spacing: 1 selects 4, 0 selects 8 |
| call_lo | input | 3 | Programmed address bits 7..5 |
| call_hi | input | 8 | Programmed address bits 15..8 |
| vec_top | input | 5 | Programmed upper five vector bits |
| auto_clr | input | 1 | Automatic in-service clear enable |
| chain_en | input | 1 | Chained (multi-device) system |
| chain_master | input | 1 | This device is the chain master |
| chain_map | input | 8 | Master: inputs that feed a slave |
| chain_id | input | 3 | Slave: own chain ID |
| casc_in | input | 3 | Chain bus as seen by a slave |
| vec_byte | output | 8 | Data byte toward the bus |
| vec_oe | output | 1 | Data bus drive enable |
| casc_out | output | 3 | Chain bus value from a master |
| casc_oe | output | 1 | Chain bus drive enable |
| isr_clr | output | 1 | One-clock automatic clear pulse |
| isr_clr_lvl | output | 3 | Level cleared by isr_clr |

## Verification
The sequencer is driven with complete three-pulse sequences at both call spacings and with two-pulse sequences. Together these separate the byte formats and show that the sequence end falls on the right pulse count. Sequences with no valid request, and with the level changed between pulses, show the first-pulse capture and the level-7 fallback. Chained master and slave runs with matching and non-matching IDs show which device owns each pulse. A long mid-sequence gap and a mid-sequence protocol switch show that a stale count is discarded rather than continued.

// File: rtl/ivs_pkg.sv
// Shared constants and types for the acknowledge vector sequencer.
// Assumes an 8-bit data bus and eight request levels.
package ivs_pkg;
    localparam int LVL_W   = 3;
    localparam int NLVL    = 1 << LVL_W;
    localparam int BYTE_W  = 8;
    localparam logic [BYTE_W-1:0] CALL_OPCODE = 8'hCD;
    localparam logic [LVL_W-1:0]  IDLE_LEVEL  = LVL_W'(NLVL - 1);

    typedef enum logic [2:0] {
        BK_NONE,
        BK_OPCODE,
        BK_ADDR_LO,
        BK_ADDR_HI,
        BK_VECTOR
    } byte_kind_t;
endpackage

// File: rtl/ivs_pulse_track.sv
// Samples the acknowledge strobe, finds pulse edges and counts the pulses
// of one sequence. It also abandons a stale sequence on a long gap or on
// a protocol change.
// Assumes iack_n is already synchronous to clk.
module ivs_pulse_track #(
    parameter int GAP_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       iack_n,
    input  logic       wide_mode,
    output logic       pulse_start,
    output logic       pulse_end,
    output logic       first_pulse,
    output logic [1:0] pulse_num,
    output logic       seq_done,
    output logic       busy,
    output logic       mode_q
);
    localparam int GW = $clog2(GAP_LIMIT + 1);

    logic          ack_q;
    logic [1:0]    cnt;
    logic [GW-1:0] gap;
    logic          last;
    logic          abort;

    assign pulse_start = ack_q & ~iack_n;
    assign pulse_end   = ~ack_q & iack_n;
    assign busy        = (cnt != 2'd0);
    assign first_pulse = pulse_start & ~busy;
    assign pulse_num   = busy ? cnt + 2'd1 : 2'd1;
    assign last        = mode_q ? (cnt == 2'd2) : (cnt == 2'd3);
    assign seq_done    = pulse_end & busy & last;
    assign abort       = busy & iack_n & ~seq_done &
                         ((gap == GW'(GAP_LIMIT - 1)) | (wide_mode != mode_q));

    // Delayed strobe sample used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b1;
        else        ack_q <= iack_n;
    end

    // Pulse counter with end-of-sequence and abandon handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= 2'd0;
            mode_q <= 1'b0;
        end else if (pulse_start) begin
            cnt <= pulse_num;
            if (!busy) mode_q <= wide_mode;
        end else if (seq_done || abort) begin
            cnt <= 2'd0;
        end
    end

    // Counts strobe-high samples taken in mid-sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy || pulse_start) gap <= '0;
        else if (iack_n)                    gap <= gap + GW'(1);
    end
endmodule

// File: rtl/ivs_byte_build.sv
// Combinational byte former: picks the byte kind for a pulse number and
// protocol, and assembles its value from programmed fields and level.
module ivs_byte_build
    import ivs_pkg::*;
(
    input  logic                wide_mode,
    input  logic                step4,
    input  logic [1:0]          pulse_num,
    input  logic [LVL_W-1:0]    level,
    input  logic [2:0]          call_lo,
    input  logic [BYTE_W-1:0]   call_hi,
    input  logic [4:0]          vec_top,
    output byte_kind_t          kind,
    output logic [BYTE_W-1:0]   value
);
    // Select kind and value for the pulse being started.
    always_comb begin
        kind  = BK_NONE;
        value = '0;
        if (wide_mode) begin
            if (pulse_num == 2'd2) begin
                kind  = BK_VECTOR;
                value = {vec_top, level};
            end
        end else begin
            case (pulse_num)
                2'd1: begin
                    kind  = BK_OPCODE;
                    value = CALL_OPCODE;
                end
                2'd2: begin
                    kind  = BK_ADDR_LO;
                    value = step4 ? {call_lo, level, 2'b00}
                                  : {call_lo[2:1], level, 3'b000};
                end
                2'd3: begin
                    kind  = BK_ADDR_HI;
                    value = call_hi;
                end
                default: begin
                    kind  = BK_NONE;
                    value = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ivs_chain_sel.sv
// Decides which device of a chain owns each pulse, and drives the chain
// bus from a master while a sequence for a slave-fed input is open.
module ivs_chain_sel
    import ivs_pkg::*;
(
    input  logic             chain_en,
    input  logic             chain_master,
    input  logic [NLVL-1:0]  chain_map,
    input  logic [2:0]       chain_id,
    input  logic [2:0]       casc_in,
    input  logic [LVL_W-1:0] level_now,
    input  logic             busy,
    input  logic [LVL_W-1:0] level_q,
    output logic             opc_ok,
    output logic             vec_ok,
    output logic [2:0]       casc_out,
    output logic             casc_oe
);
    // Pulse ownership for opcode and vector bytes.
    always_comb begin
        opc_ok = ~chain_en | chain_master;
        if (!chain_en)        vec_ok = 1'b1;
        else if (chain_master) vec_ok = ~chain_map[level_now];
        else                  vec_ok = (casc_in == chain_id);
    end

    // Chain bus drive from the held level.
    always_comb begin
        casc_oe  = busy & chain_en & chain_master & chain_map[level_q];
        casc_out = casc_oe ? 3'(level_q) : 3'd0;
    end
endmodule

// File: rtl/ack_vector_seq.sv
// Top of the acknowledge vector sequencer. It captures the level at the
// first pulse, registers the bus byte and enable per pulse, and issues the
// automatic clear pulse. Assumes priority resolution happens elsewhere and
// that all inputs are synchronous to clk.
module ack_vector_seq
    import ivs_pkg::*;
#(
    parameter int GAP_LIMIT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        iack_n,
    input  logic        req_valid,
    input  logic [2:0]  req_level,
    input  logic        wide_mode,
    input  logic        step4,
    input  logic [2:0]  call_lo,
    input  logic [7:0]  call_hi,
    input  logic [4:0]  vec_top,
    input  logic        auto_clr,
    input  logic        chain_en,
    input  logic        chain_master,
    input  logic [7:0]  chain_map,
    input  logic [2:0]  chain_id,
    input  logic [2:0]  casc_in,
    output logic [7:0]  vec_byte,
    output logic        vec_oe,
    output logic [2:0]  casc_out,
    output logic        casc_oe,
    output logic        isr_clr,
    output logic [2:0]  isr_clr_lvl
);
    logic             pulse_start, pulse_end, first_pulse, seq_done, busy, mode_q;
    logic [1:0]       pulse_num;
    logic [LVL_W-1:0] level_q, level_use;
    logic             mode_use;
    byte_kind_t       kind;
    logic [7:0]       value;
    logic             opc_ok, vec_ok, drive, owned;

    assign level_use = first_pulse ? (req_valid ? req_level : IDLE_LEVEL) : level_q;
    assign mode_use  = first_pulse ? wide_mode : mode_q;

    ivs_pulse_track #(.GAP_LIMIT(GAP_LIMIT)) u_track (
        .clk(clk), .rst_n(rst_n), .iack_n(iack_n), .wide_mode(wide_mode),
        .pulse_start(pulse_start), .pulse_end(pulse_end),
        .first_pulse(first_pulse), .pulse_num(pulse_num),
        .seq_done(seq_done), .busy(busy), .mode_q(mode_q)
    );

    ivs_byte_build u_build (
        .wide_mode(mode_use), .step4(step4), .pulse_num(pulse_num),
        .level(level_use), .call_lo(call_lo), .call_hi(call_hi),
        .vec_top(vec_top), .kind(kind), .value(value)
    );

    ivs_chain_sel u_chain (
        .chain_en(chain_en), .chain_master(chain_master), .chain_map(chain_map),
        .chain_id(chain_id), .casc_in(casc_in), .level_now(level_use),
        .busy(busy), .level_q(level_q), .opc_ok(opc_ok), .vec_ok(vec_ok),
        .casc_out(casc_out), .casc_oe(casc_oe)
    );

    assign drive = ((kind == BK_OPCODE) & opc_ok) |
                   (((kind == BK_ADDR_LO) | (kind == BK_ADDR_HI) | (kind == BK_VECTOR)) & vec_ok);

    // Bus byte, enable, held level and ownership per pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_oe   <= 1'b0;
            vec_byte <= '0;
            level_q  <= '0;
            owned    <= 1'b0;
        end else if (pulse_start) begin
            vec_oe   <= drive;
            vec_byte <= drive ? value : 8'd0;
            if (first_pulse) begin
                level_q <= level_use;
                owned   <= opc_ok;
            end else if (drive) begin
                owned   <= 1'b1;
            end
        end else if (pulse_end) begin
            vec_oe   <= 1'b0;
            vec_byte <= '0;
        end
    end

    // Automatic clear pulse at the close of a sequence this device served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_clr     <= 1'b0;
            isr_clr_lvl <= '0;
        end else begin
            isr_clr <= seq_done & auto_clr & owned;
            if (seq_done && auto_clr && owned) isr_clr_lvl <= level_q;
        end
    end
endmodule

// File: rtl/ack_vector_seq_chk.sv
// Property checker for the acknowledge vector sequencer, bound to the top.
module ack_vector_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       iack_n,
    input logic       auto_clr,
    input logic       chain_en,
    input logic       chain_master,
    input logic [2:0] chain_id,
    input logic [2:0] casc_in,
    input logic [7:0] vec_byte,
    input logic       vec_oe,
    input logic       casc_oe,
    input logic       isr_clr
);
    a_r13_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> vec_byte == 8'd0);
    a_r2_oe_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_oe) |-> !$past(iack_n));
    a_r2_oe_drops_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vec_oe) |-> $past(iack_n));
    a_r8_chain_master_only: assert property (@(posedge clk) disable iff (!rst_n)
        casc_oe |-> (chain_en && chain_master));
    a_r9_slave_match: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && chain_en && !chain_master) |-> $past(casc_in) == $past(chain_id));
    a_r10_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        isr_clr |=> !isr_clr);
    a_r10_clear_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        isr_clr |-> $past(auto_clr));
endmodule

bind ack_vector_seq ack_vector_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .iack_n(iack_n), .auto_clr(auto_clr),
    .chain_en(chain_en), .chain_master(chain_master), .chain_id(chain_id),
    .casc_in(casc_in), .vec_byte(vec_byte), .vec_oe(vec_oe),
    .casc_oe(casc_oe), .isr_clr(isr_clr)
);

// File: tb/test_ack_vector_seq.sv
`timescale 1ns/1ps
module test_ack_vector_seq;
    localparam int GAP = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iack_n = 1'b1;
    logic       req_valid = 1'b1;
    logic [2:0] req_level = 3'd0;
    logic       wide_mode = 1'b0;
    logic       step4 = 1'b1;
    logic [2:0] call_lo = 3'd0;
    logic [7:0] call_hi = 8'd0;
    logic [4:0] vec_top = 5'd0;
    logic       auto_clr = 1'b0;
    logic       chain_en = 1'b0;
    logic       chain_master = 1'b0;
    logic [7:0] chain_map = 8'd0;
    logic [2:0] chain_id = 3'd0;
    logic [2:0] casc_in = 3'd0;
    logic [7:0] vec_byte;
    logic       vec_oe;
    logic [2:0] casc_out;
    logic       casc_oe;
    logic       isr_clr;
    logic [2:0] isr_clr_lvl;

    int errors = 0;
    int checks = 0;
    string tag = "R13";
    bit done = 1'b0;

    always #10 clk = ~clk;

    ack_vector_seq #(.GAP_LIMIT(GAP)) i_ack_vector_seq (.*);

    task automatic chk(input string t, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", t, got, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced at each rising edge.
    bit         m_prev = 1'b1;
    int         m_p = 0, m_gap = 0;
    bit         m_mode = 1'b0, m_own = 1'b0, m_oe = 1'b0, m_eoi = 1'b0;
    logic [2:0] m_lvl = 3'd0, m_eoil = 3'd0;
    logic [7:0] m_data = 8'd0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 1'b1; m_p = 0; m_gap = 0; m_mode = 1'b0; m_own = 1'b0;
            m_oe = 1'b0; m_eoi = 1'b0; m_lvl = 3'd0; m_eoil = 3'd0; m_data = 8'd0;
        end else begin
            bit fall, rise, fin, vok;
            int n;
            fall = m_prev && !iack_n;
            rise = !m_prev && iack_n;
            fin  = (m_p != 0) && (m_p == (m_mode ? 2 : 3));
            m_eoi = 1'b0;
            if (fall) begin
                n = (m_p == 0) ? 1 : m_p + 1;
                if (m_p == 0) begin
                    m_mode = wide_mode;
                    m_lvl  = req_valid ? req_level : 3'd7;
                    m_own  = !chain_en || chain_master;
                end
                if (!chain_en) vok = 1'b1;
                else if (chain_master) vok = !chain_map[m_lvl];
                else vok = (casc_in == chain_id);
                m_oe = 1'b0; m_data = 8'd0;
                if (!m_mode && n == 1) begin
                    if (!chain_en || chain_master) begin m_oe = 1'b1; m_data = 8'hCD; end
                end else if (vok && (m_mode ? n == 2 : n >= 2)) begin
                    m_oe = 1'b1; m_own = 1'b1;
                    if (m_mode) m_data = {vec_top, m_lvl};
                    else if (n == 3) m_data = call_hi;
                    else if (step4) m_data = {call_lo, m_lvl, 2'b00};
                    else m_data = {call_lo[2:1], m_lvl, 3'b000};
                end
                m_p = n; m_gap = 0;
            end else if (rise && fin) begin
                m_oe = 1'b0; m_data = 8'd0; m_p = 0; m_gap = 0;
                if (auto_clr && m_own) begin m_eoi = 1'b1; m_eoil = m_lvl; end
            end else begin
                if (rise) begin m_oe = 1'b0; m_data = 8'd0; end
                if (m_p != 0 && iack_n) begin
                    m_gap++;
                    if (m_gap >= GAP || wide_mode != m_mode) begin m_p = 0; m_gap = 0; end
                end
            end
            m_prev = iack_n;
        end
    end

    // Per-clock comparison and capture, a quarter period after the edge.
    int         nb = 0, eoi_cnt = 0;
    logic [7:0] bytes [8];
    logic [2:0] cas_seen = 3'd0, eoi_lv = 3'd0;
    bit         prev_oe = 1'b0;

    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            bit ecoe;
            ecoe = (m_p != 0) && chain_en && chain_master && chain_map[m_lvl];
            chk({tag, " vec_oe"}, int'(vec_oe), int'(m_oe));
            chk({tag, " vec_byte"}, int'(vec_byte), int'(m_data));
            chk({tag, " casc_oe"}, int'(casc_oe), int'(ecoe));
            chk({tag, " casc_out"}, int'(casc_out), ecoe ? int'(m_lvl) : 0);
            chk({tag, " isr_clr"}, int'(isr_clr), int'(m_eoi));
            chk({tag, " isr_clr_lvl"}, int'(isr_clr_lvl), int'(m_eoil));
            if (vec_oe && !prev_oe && nb < 8) begin bytes[nb] = vec_byte; nb++; end
            prev_oe = vec_oe;
            if (casc_oe) cas_seen = casc_out;
            if (isr_clr) begin eoi_cnt++; eoi_lv = isr_clr_lvl; end
        end
    end

    task automatic clr_cap();
        nb = 0; eoi_cnt = 0; cas_seen = 3'd0; eoi_lv = 3'd0;
        for (int i = 0; i < 8; i++) bytes[i] = 8'd0;
    endtask

    task automatic one_pulse();
        @(negedge clk) iack_n = 1'b0;
        repeat (3) @(negedge clk);
        iack_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_pulses(input int n);
        for (int i = 0; i < n; i++) one_pulse();
        repeat (3) @(negedge clk);
    endtask

    task automatic plain_cfg();
        @(negedge clk);
        req_valid = 1'b1; wide_mode = 1'b0; step4 = 1'b1; auto_clr = 1'b0;
        chain_en = 1'b0; chain_master = 1'b0; chain_map = 8'd0;
        chain_id = 3'd0; casc_in = 3'd0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got hung expected finish");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 vec_oe", int'(vec_oe), 0);
        chk("R1 vec_byte", int'(vec_byte), 0);
        chk("R1 casc_oe", int'(casc_oe), 0);
        chk("R1 isr_clr", int'(isr_clr), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2, R3, R5: call protocol, spacing 4
        tag = "R3"; plain_cfg();
        req_level = 3'd5; call_lo = 3'b101; call_hi = 8'h9A; clr_cap();
        run_pulses(3);
        chk("R2 count", nb, 3);
        chk("R2 opcode", int'(bytes[0]), 8'hCD);
        chk("R3 low byte", int'(bytes[1]), 8'hB4);
        chk("R5 high byte", int'(bytes[2]), 8'h9A);

        // R4: spacing 8
        tag = "R4"; step4 = 1'b0; req_level = 3'd3; clr_cap();
        run_pulses(3);
        chk("R4 low byte", int'(bytes[1]), 8'h98);

        // R6: vector protocol
        tag = "R6"; wide_mode = 1'b1; vec_top = 5'b10001; req_level = 3'd6; clr_cap();
        run_pulses(2);
        chk("R6 count", nb, 1);
        chk("R6 vector", int'(bytes[0]), 8'h8E);

        // R7: no valid request, then level change mid-sequence
        tag = "R7"; req_valid = 1'b0; clr_cap();
        run_pulses(2);
        chk("R7 fallback level", int'(bytes[0]), 8'h8F);
        req_valid = 1'b1; req_level = 3'd2; clr_cap();
        one_pulse();
        req_level = 3'd5;
        run_pulses(1);
        chk("R7 held level", int'(bytes[0]), 8'h8A);

        // R8: master whose input feeds a slave
        tag = "R8"; plain_cfg();
        chain_en = 1'b1; chain_master = 1'b1; chain_map = 8'h04; req_level = 3'd2; clr_cap();
        run_pulses(3);
        chk("R8 count", nb, 1);
        chk("R8 opcode", int'(bytes[0]), 8'hCD);
        chk("R8 chain level", int'(cas_seen), 2);

        // R9: slave with and without ID match
        tag = "R9"; chain_master = 1'b0; chain_id = 3'd4; casc_in = 3'd4;
        req_level = 3'd1; step4 = 1'b1; call_lo = 3'b010; call_hi = 8'h5C; clr_cap();
        run_pulses(3);
        chk("R9 count", nb, 2);
        chk("R9 low byte", int'(bytes[0]), 8'h44);
        chk("R9 high byte", int'(bytes[1]), 8'h5C);
        casc_in = 3'd1; auto_clr = 1'b1; clr_cap();
        run_pulses(3);
        chk("R9 no match", nb, 0);
        chk("R10 unmatched slave", eoi_cnt, 0);

        // R10: automatic clear on and off
        tag = "R10"; plain_cfg(); auto_clr = 1'b1; req_level = 3'd4; clr_cap();
        run_pulses(3);
        chk("R10 pulses", eoi_cnt, 1);
        chk("R10 level", int'(eoi_lv), 4);
        auto_clr = 1'b0; clr_cap();
        run_pulses(3);
        chk("R10 disabled", eoi_cnt, 0);

        // R11: long gap abandons the sequence
        tag = "R11"; clr_cap();
        one_pulse();
        repeat (GAP + 6) @(negedge clk);
        run_pulses(3);
        chk("R11 count", nb, 4);
        chk("R11 restart opcode", int'(bytes[1]), 8'hCD);
        chk("R11 high byte", int'(bytes[3]), 8'h5C);

        // R12: protocol switch mid-sequence
        tag = "R12"; req_level = 3'd3; vec_top = 5'b00110; clr_cap();
        one_pulse();
        wide_mode = 1'b1;
        repeat (2) @(negedge clk);
        run_pulses(2);
        chk("R12 count", nb, 2);
        chk("R12 vector", int'(bytes[1]), 8'h33);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule